// File: doc/BRIEF.md
# Flash Busy-Read Status Generator

This block produces the byte a NOR flash array places on its data bus when the host reads it while an internal program or erase algorithm is still running. The host starts operations with single-cycle command strobes. These are a program start carrying the data to be written, a sector-erase request carrying a sector number, erase suspend and resume, and a reset command. The internal algorithm reports completion with `op_done_i`, and an external fault event can force a time-limit failure. On every read strobe the block returns either a status byte or the array data that the host supplies, one cycle later.

The status byte carries five flags. Bit 7 is a polling bit that shows the complement of the programmed data's top bit until completion. Bits 6 and 2 are two toggle bits whose behaviour depends on the current mode and on whether the read hits a sector queued for erase. Bit 5 reports an exceeded time limit. Bit 3 reports whether the erase acceptance window has closed. The block also keeps the set of sectors queued for erase. While the acceptance window is open, the set grows. Once the window closes, the set is frozen.

Top module: `nor_op_status`

## Requirements
- R1: During a program started from idle, a status read returns bit 7 = inverse of bit 7 of the programmed data, bit 6 = the first-toggle flop (0 on the first read after the start, inverting on each later read), bit 2 = 1, bit 3 = 0.
- R2: During erase (window open or erase running), bit 7 reads 0 and bit 6 inverts on every read. Bit 2 inverts only on reads of a sector in the erase set, and a read of any other sector returns bit 2 unchanged and leaves it unchanged.
- R3: In suspend-read mode, a read of a sector in the erase set returns bits 7 and 6 as 1 (bit 6 does not toggle) and bit 2 toggling. A read of any other sector returns the array data with `rd_status_o` low.
- R4: A program started in suspend-read mode enters suspend-program mode. There, reads outside the erase set return bit 7 = inverse of data bit 7, bit 6 toggling from 0 and bit 2 = 1, while reads of erase-set sectors behave as in R3. `op_done_i` returns the block to suspend-read without a `done_o` pulse.
- R5: The first erase request opens a window of WINDOW_CYC cycles, during which bit 3 reads 0. With RESTART_WINDOW = 1, every accepted request restarts the window. When the window expires, the erase runs and bit 3 reads 1 in the erase, suspend-read and suspend-program modes.
- R6: Erase requests arriving while the window is open add their sector to `erase_set_o`. Requests arriving once the erase is running leave `erase_set_o` unchanged.
- R7: If a program or erase runs for LIMIT_CYC cycles without completing, or `fault_i` is asserted during it, bit 5 becomes 1. From then on `op_done_i`, suspend and resume are ignored, `busy_o` stays 1 and no `done_o` pulse appears until `cmd_reset_i`.
- R8: `op_done_i` in program or erase mode returns the block to idle with a one-cycle `done_o` pulse and clears `erase_set_o`. In idle, reads return `array_data_i` with `rd_status_o` low.
- R9: `cmd_reset_i` returns the block to idle from any mode and clears bit 5, both toggle flops and the erase set. Starting an erase from idle clears both toggle flops, and starting any program clears the first-toggle flop.
- R10: `rd_valid_o` pulses one cycle after `rd_i`, with `rd_data_o` holding the result. In a status byte, bits 4, 1, 0 and all bits above 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_prog_i | input | 1 | Program start strobe |
| prog_data_i | input | DATA_W | Data being programmed |
| cmd_erase_i | input | 1 | Sector-erase request strobe |
| erase_sector_i | input | log2(NUM_SECT) | Sector of the erase request |
| suspend_i | input | 1 | Erase suspend strobe |
| resume_i | input | 1 | Erase resume strobe |
| cmd_reset_i | input | 1 | Reset command strobe |
| op_done_i | input | 1 | Internal algorithm completion |
| fault_i | input | 1 | Forces the time-limit failure |
| rd_i | input | 1 | Read strobe |
| rd_sector_i | input | log2(NUM_SECT) | Sector addressed by the read |
| array_data_i | input | DATA_W | True array contents at the read address |
| rd_valid_o | output | 1 | Read result valid |
| rd_status_o | output | 1 | Read result is a status byte |
| rd_data_o | output | DATA_W | Read result |
| done_o | output | 1 | Operation completed pulse |
| busy_o | output | 1 | An operation is in progress |
| erase_set_o | output | NUM_SECT | Sectors queued for erase |

## Verification
The bench builds the block with four sectors, a six-cycle erase window with restart enabled, and a forty-cycle time limit. The short window lets a test place a second erase request late in the window and then read just before and just after the restarted expiry, which separates restart from fixed timing. The forty-cycle limit makes a stalled program reach the failure flag within a few dozen cycles. The same limit stays long enough that the full erase, suspend, program and resume sequence finishes without tripping it.

// File: rtl/nor_stat_pkg.sv
package nor_stat_pkg;

   typedef enum logic [2:0] {
      MD_IDLE  = 3'd0,
      MD_PROG  = 3'd1,
      MD_WIN   = 3'd2,
      MD_ERASE = 3'd3,
      MD_SREAD = 3'd4,
      MD_SPROG = 3'd5
   } mode_e;

   // status byte bit positions (decoded by host polling software)
   localparam int POS_POLL = 7;
   localparam int POS_TGA  = 6;
   localparam int POS_LIM  = 5;
   localparam int POS_WIN  = 3;
   localparam int POS_TGB  = 2;

   // toggle flop indexes
   localparam int TG_A   = 0;
   localparam int TG_B   = 1;
   localparam int TG_NUM = 2;

   function automatic logic timed_mode(input mode_e m);
      return (m == MD_PROG) || (m == MD_ERASE) || (m == MD_SPROG);
   endfunction

endpackage

// File: rtl/nor_stat_tgl.sv
module nor_stat_tgl (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic flip_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (clr_i)  q_o <= 1'b0;
      else if (flip_i) q_o <= ~q_o;
   end

endmodule

// File: rtl/nor_stat_seq.sv
module nor_stat_seq
   import nor_stat_pkg::*;
#(
   parameter int NUM_SECT       = 8,
   parameter int SECT_W         = 3,
   parameter int WINDOW_CYC     = 16,
   parameter int LIMIT_CYC      = 64,
   parameter bit RESTART_WINDOW = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_prog_i,
   input  logic                prog_msb_i,
   input  logic                cmd_erase_i,
   input  logic [SECT_W-1:0]   erase_sector_i,
   input  logic                suspend_i,
   input  logic                resume_i,
   input  logic                cmd_reset_i,
   input  logic                op_done_i,
   input  logic                fault_i,
   output mode_e               mode_o,
   output logic [NUM_SECT-1:0] erase_set_o,
   output logic                prog_msb_o,
   output logic                fail_o,
   output logic                done_o,
   output logic [TG_NUM-1:0]   clr_o
);

   localparam int WIN_W = $clog2(WINDOW_CYC + 1);
   localparam int LIM_W = $clog2(LIMIT_CYC + 1);

   mode_e               mode_q, mode_d;
   logic [NUM_SECT-1:0] set_q, set_d, sect_hot;
   logic                msb_q, msb_d;
   logic                fail_q, fail_d;
   logic                done_q, done_d;
   logic [WIN_W-1:0]    win_q, win_d;
   logic [LIM_W-1:0]    lim_q, lim_d;
   logic                win_expire, win_close, win_clear;
   logic [TG_NUM-1:0]   clr_d;

   assign sect_hot   = NUM_SECT'(1) << erase_sector_i;
   assign win_expire = (win_q == WIN_W'(WINDOW_CYC - 1));

   generate
      if (RESTART_WINDOW) begin : g_restart
         assign win_close = win_expire && !cmd_erase_i;
         assign win_clear = cmd_erase_i;
      end else begin : g_fixed
         assign win_close = win_expire;
         assign win_clear = 1'b0;
      end
   endgenerate

   always_comb begin
      mode_d = mode_q;
      set_d  = set_q;
      msb_d  = msb_q;
      done_d = 1'b0;
      clr_d  = '0;
      if (cmd_reset_i) begin
         mode_d = MD_IDLE;
         set_d  = '0;
         clr_d  = '1;
      end else if (!fail_q) begin
         case (mode_q)
            MD_IDLE: begin
               if (cmd_prog_i) begin
                  mode_d      = MD_PROG;
                  msb_d       = prog_msb_i;
                  clr_d[TG_A] = 1'b1;
               end else if (cmd_erase_i) begin
                  mode_d = MD_WIN;
                  set_d  = sect_hot;
                  clr_d  = '1;
               end
            end
            MD_PROG: begin
               if (op_done_i) begin
                  mode_d = MD_IDLE;
                  done_d = 1'b1;
               end
            end
            MD_WIN: begin
               if (cmd_erase_i) set_d = set_q | sect_hot;
               if (win_close)   mode_d = MD_ERASE;
            end
            MD_ERASE: begin
               if (op_done_i) begin
                  mode_d = MD_IDLE;
                  set_d  = '0;
                  done_d = 1'b1;
               end else if (suspend_i) begin
                  mode_d = MD_SREAD;
               end
            end
            MD_SREAD: begin
               if (cmd_prog_i) begin
                  mode_d      = MD_SPROG;
                  msb_d       = prog_msb_i;
                  clr_d[TG_A] = 1'b1;
               end else if (resume_i) begin
                  mode_d = MD_ERASE;
               end
            end
            MD_SPROG: begin
               if (op_done_i) mode_d = MD_SREAD;
            end
            default: mode_d = MD_IDLE;
         endcase
      end
   end

   always_comb begin
      if (cmd_reset_i)
         fail_d = 1'b0;
      else if (fail_q)
         fail_d = 1'b1;
      else
         fail_d = timed_mode(mode_q) && (mode_d == mode_q) &&
                  (fault_i || (lim_q == LIM_W'(LIMIT_CYC - 1)));
   end

   always_comb begin
      if (mode_d != mode_q)
         lim_d = '0;
      else if (timed_mode(mode_q) && !fail_q)
         lim_d = lim_q + 1'b1;
      else
         lim_d = lim_q;
   end

   always_comb begin
      if (mode_q != MD_WIN || win_clear) win_d = '0;
      else                               win_d = win_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MD_IDLE;
         set_q  <= '0;
         msb_q  <= 1'b0;
         fail_q <= 1'b0;
         done_q <= 1'b0;
         win_q  <= '0;
         lim_q  <= '0;
      end else begin
         mode_q <= mode_d;
         set_q  <= set_d;
         msb_q  <= msb_d;
         fail_q <= fail_d;
         done_q <= done_d;
         win_q  <= win_d;
         lim_q  <= lim_d;
      end
   end

   assign mode_o      = mode_q;
   assign erase_set_o = set_q;
   assign prog_msb_o  = msb_q;
   assign fail_o      = fail_q;
   assign done_o      = done_q;
   assign clr_o       = clr_d;

endmodule

// File: rtl/nor_stat_fmt.sv
module nor_stat_fmt
   import nor_stat_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  mode_e             mode_i,
   input  logic              hit_i,
   input  logic              prog_msb_i,
   input  logic [TG_NUM-1:0] tg_i,
   input  logic              fail_i,
   output logic [DATA_W-1:0] stat_o,
   output logic              is_stat_o,
   output logic [TG_NUM-1:0] flip_o
);

   logic b_poll, b_tga, b_win, b_tgb;

   always_comb begin
      b_poll    = 1'b0;
      b_tga     = 1'b0;
      b_win     = 1'b0;
      b_tgb     = 1'b0;
      is_stat_o = 1'b1;
      flip_o    = '0;
      case (mode_i)
         MD_PROG: begin
            b_poll       = ~prog_msb_i;
            b_tga        = tg_i[TG_A];
            b_tgb        = 1'b1;
            flip_o[TG_A] = 1'b1;
         end
         MD_WIN, MD_ERASE: begin
            b_tga        = tg_i[TG_A];
            b_tgb        = tg_i[TG_B];
            b_win        = (mode_i == MD_ERASE);
            flip_o[TG_A] = 1'b1;
            flip_o[TG_B] = hit_i;
         end
         MD_SREAD, MD_SPROG: begin
            b_win = 1'b1;
            if (hit_i) begin
               b_poll       = 1'b1;
               b_tga        = 1'b1;
               b_tgb        = tg_i[TG_B];
               flip_o[TG_B] = 1'b1;
            end else if (mode_i == MD_SPROG) begin
               b_poll       = ~prog_msb_i;
               b_tga        = tg_i[TG_A];
               b_tgb        = 1'b1;
               flip_o[TG_A] = 1'b1;
            end else begin
               is_stat_o = 1'b0;
            end
         end
         default: is_stat_o = 1'b0;
      endcase
   end

   always_comb begin
      stat_o           = '0;
      stat_o[POS_POLL] = b_poll;
      stat_o[POS_TGA]  = b_tga;
      stat_o[POS_LIM]  = fail_i;
      stat_o[POS_WIN]  = b_win;
      stat_o[POS_TGB]  = b_tgb;
   end

endmodule

// File: rtl/nor_op_status.sv
module nor_op_status
   import nor_stat_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int NUM_SECT       = 8,
   parameter int WINDOW_CYC     = 16,
   parameter int LIMIT_CYC      = 64,
   parameter bit RESTART_WINDOW = 1'b1,
   localparam int SECT_W        = $clog2(NUM_SECT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_prog_i,
   input  logic [DATA_W-1:0]   prog_data_i,
   input  logic                cmd_erase_i,
   input  logic [SECT_W-1:0]   erase_sector_i,
   input  logic                suspend_i,
   input  logic                resume_i,
   input  logic                cmd_reset_i,
   input  logic                op_done_i,
   input  logic                fault_i,
   input  logic                rd_i,
   input  logic [SECT_W-1:0]   rd_sector_i,
   input  logic [DATA_W-1:0]   array_data_i,
   output logic                rd_valid_o,
   output logic                rd_status_o,
   output logic [DATA_W-1:0]   rd_data_o,
   output logic                done_o,
   output logic                busy_o,
   output logic [NUM_SECT-1:0] erase_set_o
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
      if (NUM_SECT < 2 || (1 << SECT_W) != NUM_SECT) begin : g_bad_sect
         $error("NUM_SECT must be a power of two, at least 2");
      end
      if (WINDOW_CYC < 1) begin : g_bad_window
         $error("WINDOW_CYC must be at least 1");
      end
      if (LIMIT_CYC < 2) begin : g_bad_limit
         $error("LIMIT_CYC must be at least 2");
      end
   endgenerate

   mode_e               mode_w;
   logic [NUM_SECT-1:0] set_w;
   logic                msb_w, fail_w, hit_w, is_stat_w;
   logic [TG_NUM-1:0]   clr_w, flip_w, tg_w;
   logic [DATA_W-1:0]   stat_w;
   logic                prog_unused_w;

   assign prog_unused_w = ^prog_data_i;
   assign hit_w         = set_w[rd_sector_i];

   nor_stat_seq #(
      .NUM_SECT       (NUM_SECT),
      .SECT_W         (SECT_W),
      .WINDOW_CYC     (WINDOW_CYC),
      .LIMIT_CYC      (LIMIT_CYC),
      .RESTART_WINDOW (RESTART_WINDOW)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_prog_i     (cmd_prog_i),
      .prog_msb_i     (prog_data_i[POS_POLL]),
      .cmd_erase_i    (cmd_erase_i),
      .erase_sector_i (erase_sector_i),
      .suspend_i      (suspend_i),
      .resume_i       (resume_i),
      .cmd_reset_i    (cmd_reset_i),
      .op_done_i      (op_done_i),
      .fault_i        (fault_i),
      .mode_o         (mode_w),
      .erase_set_o    (set_w),
      .prog_msb_o     (msb_w),
      .fail_o         (fail_w),
      .done_o         (done_o),
      .clr_o          (clr_w)
   );

   nor_stat_fmt #(.DATA_W(DATA_W)) u_fmt (
      .mode_i     (mode_w),
      .hit_i      (hit_w),
      .prog_msb_i (msb_w),
      .tg_i       (tg_w),
      .fail_i     (fail_w),
      .stat_o     (stat_w),
      .is_stat_o  (is_stat_w),
      .flip_o     (flip_w)
   );

   generate
      for (genvar g = 0; g < TG_NUM; g++) begin : g_tgl
         nor_stat_tgl u_tgl (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr_w[g]),
            .flip_i (rd_i & flip_w[g]),
            .q_o    (tg_w[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o  <= 1'b0;
         rd_status_o <= 1'b0;
         rd_data_o   <= '0;
      end else begin
         rd_valid_o <= rd_i;
         if (rd_i) begin
            rd_status_o <= is_stat_w;
            rd_data_o   <= is_stat_w ? stat_w : array_data_i;
         end
      end
   end

   assign busy_o      = (mode_w != MD_IDLE);
   assign erase_set_o = set_w;

endmodule

// File: rtl/nor_op_status_chk.sv
module nor_op_status_chk
   import nor_stat_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int NUM_SECT       = 8,
   parameter int SECT_W         = 3,
   parameter int WINDOW_CYC     = 16,
   parameter bit RESTART_WINDOW = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input mode_e               mode,
   input logic                fail,
   input logic [NUM_SECT-1:0] erase_set,
   input logic                cmd_erase_i,
   input logic                cmd_reset_i,
   input logic                op_done_i,
   input logic                rd_i,
   input logic [SECT_W-1:0]   rd_sector_i,
   input logic [DATA_W-1:0]   array_data_i,
   input logic                rd_valid_o,
   input logic                rd_status_o,
   input logic [DATA_W-1:0]   rd_data_o,
   input logic                done_o,
   input logic                busy_o
);

   localparam int WC_W = $clog2(WINDOW_CYC + 2) + 1;

   logic [WC_W-1:0] wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            wcnt <= '0;
      else if (mode != MD_WIN)               wcnt <= '0;
      else if (RESTART_WINDOW && cmd_erase_i) wcnt <= '0;
      else                                   wcnt <= wcnt + 1'b1;
   end

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> rd_valid_o);

   a_r8_idle_array: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && mode == MD_IDLE) |=> (!rd_status_o && rd_data_o == $past(array_data_i)));

   a_r2_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && (mode == MD_WIN || mode == MD_ERASE)) |=> (rd_status_o && !rd_data_o[POS_POLL]));

   a_r3_susp_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && mode == MD_SREAD && erase_set[rd_sector_i]) |=> (rd_data_o[POS_POLL] && rd_data_o[POS_TGA]));

   a_r6_set_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_ERASE && !op_done_i && !cmd_reset_i) |=> $stable(erase_set));

   a_r7_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !cmd_reset_i) |=> (fail && busy_o));

   a_r7_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> !done_o);

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_WIN) |-> (wcnt < WC_W'(WINDOW_CYC)));

endmodule

bind nor_op_status nor_op_status_chk #(
   .DATA_W         (DATA_W),
   .NUM_SECT       (NUM_SECT),
   .SECT_W         (SECT_W),
   .WINDOW_CYC     (WINDOW_CYC),
   .RESTART_WINDOW (RESTART_WINDOW)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode         (mode_w),
   .fail         (fail_w),
   .erase_set    (set_w),
   .cmd_erase_i  (cmd_erase_i),
   .cmd_reset_i  (cmd_reset_i),
   .op_done_i    (op_done_i),
   .rd_i         (rd_i),
   .rd_sector_i  (rd_sector_i),
   .array_data_i (array_data_i),
   .rd_valid_o   (rd_valid_o),
   .rd_status_o  (rd_status_o),
   .rd_data_o    (rd_data_o),
   .done_o       (done_o),
   .busy_o       (busy_o)
);

// File: tb/nor_op_status_tb.sv
module nor_op_status_tb_top;

   localparam int DW = 8;
   localparam int NS = 4;
   localparam int SW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_prog_i = 1'b0, cmd_erase_i = 1'b0, suspend_i = 1'b0, resume_i = 1'b0;
   logic cmd_reset_i = 1'b0, op_done_i = 1'b0, fault_i = 1'b0, rd_i = 1'b0;
   logic [DW-1:0] prog_data_i = '0, array_data_i = '0;
   logic [SW-1:0] erase_sector_i = '0, rd_sector_i = '0;
   logic rd_valid_o, rd_status_o, done_o, busy_o;
   logic [DW-1:0] rd_data_o;
   logic [NS-1:0] erase_set_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic m6 = 1'b0;
   logic m2 = 1'b0;
   logic r_valid, r_stat;
   logic [DW-1:0] r_data;

   always #10ns clk = ~clk;

   nor_op_status #(
      .DATA_W(DW), .NUM_SECT(NS), .WINDOW_CYC(6), .LIMIT_CYC(40), .RESTART_WINDOW(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_prog_i(cmd_prog_i), .prog_data_i(prog_data_i),
      .cmd_erase_i(cmd_erase_i), .erase_sector_i(erase_sector_i), .suspend_i(suspend_i),
      .resume_i(resume_i), .cmd_reset_i(cmd_reset_i), .op_done_i(op_done_i),
      .fault_i(fault_i), .rd_i(rd_i), .rd_sector_i(rd_sector_i),
      .array_data_i(array_data_i), .rd_valid_o(rd_valid_o), .rd_status_o(rd_status_o),
      .rd_data_o(rd_data_o), .done_o(done_o), .busy_o(busy_o), .erase_set_o(erase_set_o)
   );

   // {programmed data, array data returned after completion}
   localparam logic [15:0] PROG_VEC [6] = '{
      16'h80_11, 16'h7F_22, 16'hFF_A5, 16'h00_5A, 16'hC3_F0, 16'h3C_0F
   };

   function automatic logic [DW-1:0] stat(input logic b7, b6, b5, b3, b2);
      stat = {b7, b6, b5, 1'b0, b3, b2, 2'b00};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_read(input logic [SW-1:0] sec, input logic [DW-1:0] arr);
      rd_i = 1'b1; rd_sector_i = sec; array_data_i = arr;
      @(negedge clk);
      rd_i = 1'b0;
      r_valid = rd_valid_o; r_stat = rd_status_o; r_data = rd_data_o;
   endtask

   task automatic prog(input logic [DW-1:0] d);
      cmd_prog_i = 1'b1; prog_data_i = d;
      @(negedge clk);
      cmd_prog_i = 1'b0;
   endtask

   task automatic erase(input logic [SW-1:0] s);
      cmd_erase_i = 1'b1; erase_sector_i = s;
      @(negedge clk);
      cmd_erase_i = 1'b0;
   endtask

   // 0 done, 1 suspend, 2 resume, 3 reset cmd, 4 fault
   task automatic strobe(input int which);
      case (which)
         0: op_done_i = 1'b1;
         1: suspend_i = 1'b1;
         2: resume_i = 1'b1;
         3: cmd_reset_i = 1'b1;
         default: fault_i = 1'b1;
      endcase
      @(negedge clk);
      op_done_i = 1'b0; suspend_i = 1'b0; resume_i = 1'b0; cmd_reset_i = 1'b0; fault_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d, a;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // reset state
      chk("R8 reset busy", busy_o, 0);
      chk("R10 reset valid", rd_valid_o, 0);
      chk("R8 reset done", done_o, 0);
      chk("R6 reset set", erase_set_o, 0);
      do_read(1, 8'h6B);
      chk("R10 idle valid", r_valid, 1);
      chk("R8 idle array", {r_stat, r_data}, {1'b0, 8'h6B});

      // table walk: program polling and completion
      for (int i = 0; i < 6; i++) begin
         d = PROG_VEC[i][15:8];
         a = PROG_VEC[i][7:0];
         prog(d);
         m6 = 1'b0;
         chk("R1 busy", busy_o, 1);
         do_read(0, ~a);
         chk("R1 first read", {r_stat, r_data}, {1'b1, stat(~d[7], m6, 0, 0, 1)});
         m6 = ~m6;
         do_read(2, ~a);
         chk("R1 second read", {r_stat, r_data}, {1'b1, stat(~d[7], m6, 0, 0, 1)});
         m6 = ~m6;
         strobe(0);
         chk("R8 done pulse", done_o, 1);
         do_read(3, a);
         chk("R8 done single", done_o, 0);
         chk("R8 array after done", {r_stat, r_data}, {1'b0, a});
      end

      // erase with window
      erase(0);
      m6 = 1'b0; m2 = 1'b0;
      do_read(0, 8'h00);
      chk("R2 window hit read", r_data, stat(0, m6, 0, 0, m2));
      m6 = ~m6; m2 = ~m2;
      do_read(0, 8'h00);
      chk("R2 window hit read2", r_data, stat(0, m6, 0, 0, m2));
      m6 = ~m6; m2 = ~m2;
      do_read(2, 8'h00);
      chk("R2 non-hit keeps bit2", r_data, stat(0, m6, 0, 0, m2));
      m6 = ~m6;
      erase(1);
      chk("R6 added sector", erase_set_o, 4'b0011);
      repeat (4) tick();
      do_read(1, 8'h00);
      chk("R5 restarted window open", r_data, stat(0, m6, 0, 0, m2));
      m6 = ~m6; m2 = ~m2;
      tick();
      do_read(2, 8'h00);
      chk("R5 window closed", r_data, stat(0, m6, 0, 1, m2));
      m6 = ~m6;
      erase(3);
      chk("R6 ignored after window", erase_set_o, 4'b0011);

      // suspend read
      strobe(1);
      do_read(0, 8'h00);
      chk("R3 suspended hit", {r_stat, r_data}, {1'b1, stat(1, 1, 0, 1, m2)});
      m2 = ~m2;
      do_read(1, 8'h00);
      chk("R3 suspended hit2", {r_stat, r_data}, {1'b1, stat(1, 1, 0, 1, m2)});
      m2 = ~m2;
      do_read(2, 8'hE7);
      chk("R3 outside array", {r_stat, r_data}, {1'b0, 8'hE7});

      // suspend program
      prog(8'h5A);
      m6 = 1'b0;
      do_read(2, 8'h00);
      chk("R4 sprog read", r_data, stat(1, m6, 0, 1, 1));
      m6 = ~m6;
      do_read(3, 8'h00);
      chk("R4 sprog read2", r_data, stat(1, m6, 0, 1, 1));
      m6 = ~m6;
      do_read(0, 8'h00);
      chk("R4 sprog suspended hit", r_data, stat(1, 1, 0, 1, m2));
      m2 = ~m2;
      strobe(0);
      chk("R4 no done pulse", {done_o, busy_o}, 2'b01);
      do_read(1, 8'h00);
      chk("R4 back to suspend read", r_data, stat(1, 1, 0, 1, m2));
      m2 = ~m2;
      do_read(3, 8'h99);
      chk("R4 suspend read array", {r_stat, r_data}, {1'b0, 8'h99});

      // resume and finish
      strobe(2);
      do_read(3, 8'h00);
      chk("R2 resumed erase", r_data, stat(0, m6, 0, 1, m2));
      m6 = ~m6;
      strobe(0);
      chk("R8 erase done pulse", done_o, 1);
      chk("R8 erase set cleared", {busy_o, erase_set_o}, 5'b0_0000);

      // time limit
      prog(8'hFF);
      m6 = 1'b0;
      repeat (45) tick();
      do_read(0, 8'h00);
      chk("R7 limit flag", r_data, stat(0, m6, 1, 0, 1));
      m6 = ~m6;
      strobe(0);
      chk("R7 done ignored", {done_o, busy_o}, 2'b01);
      do_read(0, 8'h00);
      chk("R7 flag sticky", r_data, stat(0, m6, 1, 0, 1));
      strobe(3);
      chk("R9 reset cmd idle", busy_o, 0);
      do_read(0, 8'h3D);
      chk("R9 array after reset", {r_stat, r_data}, {1'b0, 8'h3D});

      // fault event
      prog(8'h00);
      m6 = 1'b0;
      strobe(4);
      do_read(1, 8'h00);
      chk("R7 fault flag", r_data, stat(1, m6, 1, 0, 1));
      m6 = ~m6;
      strobe(3);

      // new erase clears toggles; reset cmd mid-window
      erase(2);
      do_read(2, 8'h00);
      chk("R9 toggles cleared", r_data, stat(0, 0, 0, 0, 0));
      strobe(3);
      chk("R9 window reset", {busy_o, erase_set_o}, 5'b0_0000);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule